// File: doc/BRIEF.md
# Sliding-Window Integer Register File

This block is an integer register file that shows software 32 registers at a time. Indices 0 to 7 are globals that every procedure context shares, and index 0 always reads as zero. Indices 8 to 31 reach into a ring of physical registers. That ring is split into windows, and each window holds eight private locals and eight outs. A window's incoming group (indices 24 to 31) is the same physical storage as the outs of its neighbour one step up the ring. A caller therefore leaves arguments in its outs, and after a save the callee finds them in its ins.

A save command moves the current-window pointer down by one window. A restore command moves it up by one. Both moves wrap around the ring. Before the pointer moves, the target window is checked against a window-invalid mask supplied from outside the block. If the target is marked invalid, the pointer stays where it is and a one-cycle overflow trap (on save) or underflow trap (on restore) is raised. Spilling or refilling windows is left to software. There are two combinational read ports and one synchronous write port.

Top module: `win_regfile`

## Requirements
- R1: Registers 1 to 7 are globals. A value written to one of them reads back the same after any number of saves or restores.
- R2: Register 0 reads as zero on both read ports, and a write to it is discarded.
- R3: Registers 16 to 23 are the locals of the current window. A value written there is not visible from any other window, and it reads back again when the pointer returns to that window.
- R4: Registers 24 to 31 of window w map to the same storage as registers 8 to 15 of window (w+1) mod NWIN. This holds across the wrap from NWIN-1 to 0.
- R5: A save without a trap sets the pointer to (cwp-1) mod NWIN, and a restore without a trap sets it to (cwp+1) mod NWIN. The new pointer is visible one clock after the command.
- R6: A save whose target window has its bit set in the invalid mask leaves the pointer unchanged. It drives ovf_trap high for exactly the one cycle after the command.
- R7: A restore whose target window is marked invalid leaves the pointer unchanged. It drives unf_trap high for exactly the one cycle after the command. The two traps are never high together.
- R8: A read of the register being written in the same cycle returns the old value. A write issued in the same cycle as a save or restore uses the mapping from before the move.
- R9: In the cycle after a save or restore, reads use the new window mapping.
- R10: After reset the pointer is 0, both traps are low and every register reads zero.
- R11: When save and restore are asserted together, the block acts as a save only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural index, read port A |
| rd_a_data | output | W | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural index, read port B |
| rd_b_data | output | W | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index for the write |
| wr_data | input | W | Write data |
| save | input | 1 | Move the window down one step (call) |
| restore | input | 1 | Move the window up one step (return) |
| wim | input | NWIN | Window-invalid mask, one bit per window |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | One-cycle pulse: save refused |
| unf_trap | output | 1 | One-cycle pulse: restore refused |

## Verification
The bench builds the block with NWIN=4 and W=16. With only four windows, a handful of restores carries the pointer through its full ring and across the wrap from window 3 to window 0. In that position the in group of the top window aliases the outs of window 0, and the check at that point is the one most likely to catch an off-by-one in the modulo mapping. The small window count also lets a single set mask bit land exactly on the save or restore target, which is how both trap paths are reached.

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NWIN = 8,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4:0]              rd_a_idx,
  output logic [W-1:0]            rd_a_data,
  input  logic [4:0]              rd_b_idx,
  output logic [W-1:0]            rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_idx,
  input  logic [W-1:0]            wr_data,
  input  logic                    save,
  input  logic                    restore,
  input  logic [NWIN-1:0]         wim,
  output logic [$clog2(NWIN)-1:0] cwp,
  output logic                    ovf_trap,
  output logic                    unf_trap
);
  localparam int CW    = $clog2(NWIN);
  localparam int DEPTH = NWIN * 16;
  localparam int PW    = CW + 4;

  logic [W-1:0]  glob [8];
  logic [W-1:0]  ring [DEPTH];
  logic [CW-1:0] cwp_dn, cwp_up;
  logic          do_save, do_rest, save_bad, rest_bad;

  assign cwp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
  assign cwp_up = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;

  assign save_bad = save && wim[cwp_dn];
  assign rest_bad = restore && !save && wim[cwp_up];
  assign do_save  = save && !save_bad;
  assign do_rest  = restore && !save && !rest_bad;

  function automatic logic [PW-1:0] phys(input logic [4:0] idx, input logic [CW-1:0] c,
                                         input logic [CW-1:0] cu);
    logic [CW-1:0] w;
    w = (idx[4:3] == 2'b11) ? cu : c;
    return {w, idx[4] & ~idx[3], idx[2:0]};
  endfunction

  function automatic logic [W-1:0] rd(input logic [4:0] idx);
    if (idx == 5'd0)       return '0;
    else if (idx[4:3] == 0) return glob[idx[2:0]];
    else                    return ring[phys(idx, cwp, cwp_up)];
  endfunction

  assign rd_a_data = rd(rd_a_idx);
  assign rd_b_data = rd(rd_b_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp      <= '0;
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
      for (int i = 0; i < 8; i++) glob[i] <= '0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else begin
      ovf_trap <= save_bad;
      unf_trap <= rest_bad;
      if (do_save)      cwp <= cwp_dn;
      else if (do_rest) cwp <= cwp_up;
      if (wr_en && wr_idx != 5'd0) begin
        if (wr_idx[4:3] == 0) glob[wr_idx[2:0]] <= wr_data;
        else                   ring[phys(wr_idx, cwp, cwp_up)] <= wr_data;
      end
    end
  end

  // R5
  cwp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwp != $past(cwp)) |-> $past(save || restore));

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (cwp == $past(cwp)));

  // R7
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |-> ($past(restore && !save) && cwp == $past(cwp)));

  // R7
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_trap && unf_trap));

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> $past(save));
endmodule

// File: tb/test_win_regfile.sv
module test_win_regfile;
  localparam int NWIN = 4;
  localparam int W    = 16;
  localparam int CW   = $clog2(NWIN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [W-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 1'b0, save = 1'b0, restore = 1'b0;
  logic [NWIN-1:0] wim = '0;
  logic [CW-1:0] cwp;
  logic ovf_trap, unf_trap;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  win_regfile #(.NWIN(NWIN), .W(W)) i_win_regfile (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .save(save), .restore(restore), .wim(wim), .cwp(cwp),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap));

  // op: 0 write, 1 read (val = expected), 2 save, 3 restore (val = expected cwp)
  localparam int NV = 27;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 5'd0,  16'h1234},
    {2'd1, 5'd0,  16'h0000},  // R2
    {2'd0, 5'd1,  16'h0011},
    {2'd0, 5'd7,  16'h0077},
    {2'd0, 5'd8,  16'h0A08},
    {2'd0, 5'd16, 16'h0A10},
    {2'd0, 5'd24, 16'h0A18},
    {2'd1, 5'd1,  16'h0011},  // R1
    {2'd2, 5'd0,  16'h0003},  // R5
    {2'd1, 5'd24, 16'h0A08},  // R4
    {2'd1, 5'd16, 16'h0000},  // R3
    {2'd1, 5'd7,  16'h0077},  // R1
    {2'd1, 5'd8,  16'h0000},
    {2'd0, 5'd16, 16'h0B10},
    {2'd3, 5'd0,  16'h0000},
    {2'd1, 5'd16, 16'h0A10},  // R3
    {2'd1, 5'd24, 16'h0A18},
    {2'd3, 5'd0,  16'h0001},
    {2'd1, 5'd8,  16'h0A18},  // R4
    {2'd1, 5'd24, 16'h0000},
    {2'd3, 5'd0,  16'h0002},
    {2'd3, 5'd0,  16'h0003},
    {2'd1, 5'd16, 16'h0B10},  // R3
    {2'd1, 5'd24, 16'h0A08},  // R4 wrap
    {2'd3, 5'd0,  16'h0000},  // R5 wrap
    {2'd1, 5'd16, 16'h0A10},
    {2'd1, 5'd0,  16'h0000}   // R2
  };

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_a_idx = 5'd20;
    #1;
    chk("R10 cwp", W'(cwp), '0);
    chk("R10 traps", W'({ovf_trap, unf_trap}), '0);
    chk("R10 regs", rd_a_data, '0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      case (VEC[v][22:21])
        2'd0: begin
          wr_en = 1'b1; wr_idx = VEC[v][20:16]; wr_data = VEC[v][15:0];
          @(negedge clk); wr_en = 1'b0;
        end
        2'd1: begin
          rd_a_idx = VEC[v][20:16]; #1;
          chk($sformatf("R9 vec %0d", v), rd_a_data, VEC[v][15:0]);
        end
        default: begin
          save = (VEC[v][22:21] == 2'd2); restore = !save;
          @(negedge clk); save = 1'b0; restore = 1'b0; #1;
          chk($sformatf("R5 vec %0d", v), W'(cwp), VEC[v][15:0]);
        end
      endcase
    end

    // R8 same-cycle write/read returns old value (port B)
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd2; wr_data = 16'h0222; rd_b_idx = 5'd2; #1;
    chk("R8 old value", rd_b_data, 16'h0000);
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R8 new value", rd_b_data, 16'h0222);

    // R8 write during save uses pre-move mapping
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 16'h0C09; save = 1'b1;
    @(negedge clk); wr_en = 1'b0; save = 1'b0;
    rd_a_idx = 5'd25; #1;
    chk("R8 save cwp", W'(cwp), 16'd3);
    chk("R8 write old window", rd_a_data, 16'h0C09);
    @(negedge clk); restore = 1'b1;
    @(negedge clk); restore = 1'b0; #1;
    chk("R5 back", W'(cwp), 16'd0);

    // R11 both asserted acts as save
    @(negedge clk); save = 1'b1; restore = 1'b1;
    @(negedge clk); save = 1'b0; restore = 1'b0; #1;
    chk("R11 cwp", W'(cwp), 16'd3);
    @(negedge clk); restore = 1'b1;
    @(negedge clk); restore = 1'b0;

    // R6 overflow trap: window 3 invalid, save from 0
    @(negedge clk); wim = 4'b1000; save = 1'b1;
    @(negedge clk); save = 1'b0; #1;
    chk("R6 ovf high", W'(ovf_trap), 16'd1);
    chk("R6 cwp held", W'(cwp), 16'd0);
    chk("R6 no unf", W'(unf_trap), 16'd0);
    @(negedge clk); #1;
    chk("R6 ovf one cycle", W'(ovf_trap), 16'd0);

    // R7 underflow trap: window 1 invalid, restore from 0
    @(negedge clk); wim = 4'b0010; restore = 1'b1;
    @(negedge clk); restore = 1'b0; #1;
    chk("R7 unf high", W'(unf_trap), 16'd1);
    chk("R7 cwp held", W'(cwp), 16'd0);
    chk("R7 no ovf", W'(ovf_trap), 16'd0);
    @(negedge clk); #1;
    chk("R7 unf one cycle", W'(unf_trap), 16'd0);

    @(negedge clk);
    finish_run();
  end
endmodule